// File: doc/BRIEF.md
# Load/Store Ordering Unit with Store-Wait Prediction

This block decides, for each load held in the core's memory window, whether it may execute yet with respect to the stores ahead of it in program order. Loads and stores take slots in a 16-entry circular queue in decode order. A store's address and its data are recorded as two independent events. A load becomes eligible once its own address is known and no older store stands in its way.

Address comparison uses only the low 12 bits of each address. A match on those bits counts as a true conflict. In conservative mode, an older store whose address is still unknown blocks the load. In speculative mode, the load may run ahead of unknown store addresses. If such a store later resolves onto an executed younger load, the unit raises a violation naming the oldest offending load so that the core can squash it and everything behind it. Each violation trains a 64-entry store-wait table indexed by load PC bits [7:2]. A later load from a trained PC waits until every older store has both address and data. The whole table is wiped every 4096 cycles.

The allocation port is a valid/ready stream. `alloc_ready` is low when all 16 slots are occupied and during a squash cycle. An entry is taken only on a cycle with both `alloc_valid` and `alloc_ready` high, and the producer holds its request until then. All other inputs are single-cycle event pulses with no back-pressure.

Top module: `ldst_order_unit`

## Requirements
- R1: Slots are granted in ring order starting at 0 after reset. `alloc_idx` shows the slot the next accepted entry takes. `alloc_ready` drops while 16 entries are occupied.
- R2: Store address resolution (`sa_valid`) and store data arrival (`sd_valid`) are recorded independently and may come in either order. A store counts as complete only once both have been seen.
- R3: `issue_ok[i]` is 1 only for a live load whose address has been supplied and which has not yet been marked executed. A load with no older stores in the queue gets `issue_ok` 1 one cycle after its address arrives.
- R4: An older store with a known address equal to the load's address in bits [11:0] blocks the load, even when the two addresses differ in higher bits. Addresses that differ in bits [11:0] do not block.
- R5: With `spec_mode`=0 (conservative), an older store with unknown address blocks the load. Stores younger than the load never block it.
- R6: With `spec_mode`=1 (speculative), a load whose table bit is clear may issue past older stores with unknown address.
- R7: When a store address resolves, `viol_valid` pulses for one cycle on the next cycle if some executed younger load matches it in bits [11:0]. `viol_idx` then names the oldest such load. Loads older than the store never cause a violation.
- R8: A violation sets the store-wait bit for that load's PC bits [7:2] on the cycle `viol_valid` is high. A load allocated later with a set bit gets `issue_ok` 0 until every older store has both address and data. Loads whose PCs index clear bits are unaffected.
- R9: All store-wait bits are cleared once every 4096 cycles counted from reset. A trained PC therefore issues speculatively again once a full period has passed.
- R10: `commit_valid` retires the oldest entry and frees its slot. A retired store no longer blocks any load.
- R11: `squash_valid` with `squash_idx` drops that entry and every younger one. The next accepted allocation receives slot `squash_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_mode | input | 1 | 0 conservative, 1 speculative issue past unknown store addresses |
| alloc_valid | input | 1 | Decode offers a memory operation |
| alloc_ready | output | 1 | Queue can accept an entry this cycle |
| alloc_is_store | input | 1 | 1 store, 0 load |
| alloc_pc | input | 32 | PC of the offered operation |
| alloc_idx | output | 4 | Slot the next accepted entry occupies |
| sa_valid | input | 1 | Store address resolved |
| sa_idx | input | 4 | Slot of that store |
| sa_addr | input | 32 | Store address |
| sd_valid | input | 1 | Store data arrived |
| sd_idx | input | 4 | Slot of that store |
| la_valid | input | 1 | Load address resolved |
| la_idx | input | 4 | Slot of that load |
| la_addr | input | 32 | Load address |
| lx_valid | input | 1 | Load has executed |
| lx_idx | input | 4 | Slot of that load |
| commit_valid | input | 1 | Retire the oldest entry |
| squash_valid | input | 1 | Drop entries from squash_idx onward |
| squash_idx | input | 4 | Oldest slot to drop |
| issue_ok | output | 16 | Per-slot permission for a load to execute |
| viol_valid | output | 1 | Ordering violation, squash requested |
| viol_idx | output | 4 | Oldest violating load |

## Verification
The embedded properties assume well-formed events. Every index names a live entry of the right kind: a store for address and data events, a load for load events and for `lx_valid`. A load is marked executed only while its `issue_ok` bit is 1. Commit and squash never share a cycle, and a squash point is never the head while a commit is pending. A store address never resolves in the same cycle that a load is marked executed. The directed scenarios build each case from explicit allocations with these rules respected. Each scenario begins from reset, so the 4096-cycle table period starts at a known point. The trained-PC scenario finishes well before the first clear, and the clearing scenario waits more than a full period.

// File: rtl/ldst_order_pkg.sv
package ldst_order_pkg;
  typedef enum logic {
    ORD_CONSERVATIVE = 1'b0,
    ORD_SPECULATE    = 1'b1
  } ord_mode_e;
endpackage

// File: rtl/ldst_order_swt.sv
// Store-wait predictor: one bit per PC index, wiped every PERIOD cycles.
module ldst_order_swt #(
  parameter int ENTRIES = 64,
  parameter int PERIOD  = 4096,
  parameter int IW      = $clog2(ENTRIES),
  parameter int CW      = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_bit,
  input  logic          set_valid,
  input  logic [IW-1:0] set_idx
);
  logic [ENTRIES-1:0] tbl;
  logic [CW-1:0]      tick_cnt;
  logic               clr_now;

  assign clr_now = (tick_cnt == CW'(PERIOD - 1));
  assign rd_bit  = tbl[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl      <= '0;
      tick_cnt <= '0;
    end else begin
      tick_cnt <= clr_now ? '0 : tick_cnt + 1'b1;
      if (clr_now) tbl <= '0;
      if (set_valid) tbl[set_idx] <= 1'b1;
    end
  end

  // R9: a wipe with no concurrent training leaves the table empty
  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !set_valid) |=> (tbl == '0));

  // R8: training is visible on the following cycle
  p_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> tbl[$past(set_idx)]);
endmodule

// File: rtl/ldst_order_check.sv
// Combinational ordering checks over the queue contents.
module ldst_order_check #(
  parameter int QDEPTH = 16,
  parameter int CMP_W  = 12,
  parameter int IDX_W  = $clog2(QDEPTH)
) (
  input  logic [IDX_W-1:0]             head,
  input  logic [QDEPTH-1:0]            v,
  input  logic [QDEPTH-1:0]            st,
  input  logic [QDEPTH-1:0]            aok,
  input  logic [QDEPTH-1:0]            dok,
  input  logic [QDEPTH-1:0]            ex,
  input  logic [QDEPTH-1:0]            sw,
  input  logic [QDEPTH-1:0][CMP_W-1:0] addr,
  input  logic                         spec,
  input  logic                         sa_valid,
  input  logic [IDX_W-1:0]             sa_idx,
  input  logic [CMP_W-1:0]             sa_addr,
  output logic [QDEPTH-1:0]            issue_ok,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  logic [IDX_W-1:0]  age [QDEPTH];
  logic [QDEPTH-1:0] blk;

  for (genvar g = 0; g < QDEPTH; g++) begin : g_age
    assign age[g] = IDX_W'(g) - head;
  end

  always_comb begin
    blk = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      for (int j = 0; j < QDEPTH; j++) begin
        if (v[j] && st[j] && (age[j] < age[i])) begin
          if (aok[j] && (addr[j] == addr[i])) blk[i] = 1'b1;
          if (!aok[j] && !spec)               blk[i] = 1'b1;
          if (sw[i] && !(aok[j] && dok[j]))   blk[i] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < QDEPTH; g++) begin : g_ok
    assign issue_ok[g] = v[g] && !st[g] && aok[g] && !ex[g] && !blk[g];
  end

  always_comb begin
    logic [IDX_W-1:0] s_age;
    logic [IDX_W-1:0] best;
    hit     = 1'b0;
    hit_idx = '0;
    best    = '1;
    s_age   = sa_idx - head;
    for (int i = 0; i < QDEPTH; i++) begin
      if (sa_valid && v[i] && !st[i] && ex[i] && (addr[i] == sa_addr) &&
          (age[i] > s_age) && (!hit || (age[i] < best))) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
        best    = age[i];
      end
    end
  end
endmodule

// File: rtl/ldst_order_unit.sv
module ldst_order_unit
  import ldst_order_pkg::*;
#(
  parameter int QDEPTH     = 16,
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int CMP_W      = 12,
  parameter int SW_ENTRIES = 64,
  parameter int CLR_PERIOD = 4096,
  localparam int IDX_W     = $clog2(QDEPTH),
  localparam int CNT_W     = IDX_W + 1,
  localparam int SWI_W     = $clog2(SW_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_mode,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_is_store,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              sa_valid,
  input  logic [IDX_W-1:0]  sa_idx,
  input  logic [ADDR_W-1:0] sa_addr,
  input  logic              sd_valid,
  input  logic [IDX_W-1:0]  sd_idx,
  input  logic              la_valid,
  input  logic [IDX_W-1:0]  la_idx,
  input  logic [ADDR_W-1:0] la_addr,
  input  logic              lx_valid,
  input  logic [IDX_W-1:0]  lx_idx,
  input  logic              commit_valid,
  input  logic              squash_valid,
  input  logic [IDX_W-1:0]  squash_idx,
  output logic [QDEPTH-1:0] issue_ok,
  output logic              viol_valid,
  output logic [IDX_W-1:0]  viol_idx
);
  ord_mode_e mode;
  assign mode = ord_mode_e'(spec_mode);

  logic [IDX_W-1:0]             head, tail;
  logic [CNT_W-1:0]             count;
  logic [QDEPTH-1:0]            e_v, e_st, e_aok, e_dok, e_ex, e_sw;
  logic [QDEPTH-1:0][CMP_W-1:0] e_addr;
  logic [SWI_W-1:0]             e_pci [QDEPTH];
  logic [SWI_W-1:0]             viol_pci;

  logic             alloc_fire;
  logic [SWI_W-1:0] alloc_pci;
  logic             sw_bit;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] sq_age;

  assign alloc_ready = (count != CNT_W'(QDEPTH)) && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;
  assign alloc_pci   = alloc_pc[SWI_W+1:2];
  assign sq_age      = squash_idx - head;

  ldst_order_swt #(.ENTRIES(SW_ENTRIES), .PERIOD(CLR_PERIOD)) u_swt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (alloc_pci),
    .rd_bit    (sw_bit),
    .set_valid (viol_valid),
    .set_idx   (viol_pci)
  );

  ldst_order_check #(.QDEPTH(QDEPTH), .CMP_W(CMP_W)) u_chk (
    .head     (head),
    .v        (e_v),
    .st       (e_st),
    .aok      (e_aok),
    .dok      (e_dok),
    .ex       (e_ex),
    .sw       (e_sw),
    .addr     (e_addr),
    .spec     (mode == ORD_SPECULATE),
    .sa_valid (sa_valid),
    .sa_idx   (sa_idx),
    .sa_addr  (sa_addr[CMP_W-1:0]),
    .issue_ok (issue_ok),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      e_v      <= '0;
      e_st     <= '0;
      e_aok    <= '0;
      e_dok    <= '0;
      e_ex     <= '0;
      e_sw     <= '0;
      e_addr   <= '0;
      viol_valid <= 1'b0;
      viol_idx   <= '0;
      viol_pci   <= '0;
      for (int i = 0; i < QDEPTH; i++) e_pci[i] <= '0;
    end else begin
      viol_valid <= hit && !squash_valid;
      viol_idx   <= hit_idx;
      viol_pci   <= e_pci[hit_idx];

      if (sa_valid) begin
        e_aok[sa_idx]  <= 1'b1;
        e_addr[sa_idx] <= sa_addr[CMP_W-1:0];
      end
      if (sd_valid) e_dok[sd_idx] <= 1'b1;
      if (la_valid) begin
        e_aok[la_idx]  <= 1'b1;
        e_addr[la_idx] <= la_addr[CMP_W-1:0];
      end
      if (lx_valid) e_ex[lx_idx] <= 1'b1;

      if (commit_valid) begin
        e_v[head] <= 1'b0;
        head      <= head + 1'b1;
      end

      if (squash_valid) begin
        for (int i = 0; i < QDEPTH; i++) begin
          if ((IDX_W'(i) - head) >= sq_age) e_v[i] <= 1'b0;
        end
        tail  <= squash_idx;
        count <= CNT_W'(sq_age);
      end else begin
        count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_valid);
      end

      if (alloc_fire) begin
        e_v[tail]    <= 1'b1;
        e_st[tail]   <= alloc_is_store;
        e_aok[tail]  <= 1'b0;
        e_dok[tail]  <= 1'b0;
        e_ex[tail]   <= 1'b0;
        e_sw[tail]   <= sw_bit && !alloc_is_store;
        e_pci[tail]  <= alloc_pci;
        tail         <= tail + 1'b1;
      end
    end
  end

  // R1: an accepted entry is live with its kind recorded
  p_alloc_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (e_v[$past(tail)] && (e_st[$past(tail)] == $past(alloc_is_store))));

  // R10: a lone commit shrinks occupancy by one
  p_commit_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !alloc_fire && !squash_valid) |=> (count == $past(count) - CNT_W'(1)));

  // R11: squash rewinds the allocation slot
  p_squash_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (alloc_idx == $past(squash_idx)));

  // R7: a reported violation names an executed live load
  p_viol_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (e_v[viol_idx] && !e_st[viol_idx] && e_ex[viol_idx]));

  for (genvar g = 0; g < QDEPTH; g++) begin : g_ok_chk
    // R3: permission only for a live, addressed, not yet executed load
    p_ok_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ok[g] |-> (e_v[g] && !e_st[g] && e_aok[g] && !e_ex[g]));
  end
endmodule

// File: tb/ldst_order_unit_bench.sv
module ldst_order_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spec_mode = 1'b0;
  logic        alloc_valid = 1'b0, alloc_is_store = 1'b0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [3:0]  alloc_idx;
  logic        sa_valid = 1'b0, sd_valid = 1'b0, la_valid = 1'b0, lx_valid = 1'b0;
  logic [3:0]  sa_idx = '0, sd_idx = '0, la_idx = '0, lx_idx = '0, squash_idx = '0;
  logic [31:0] sa_addr = '0, la_addr = '0;
  logic        commit_valid = 1'b0, squash_valid = 1'b0;
  logic [15:0] issue_ok;
  logic        viol_valid;
  logic [3:0]  viol_idx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ldst_order_unit u_ldst_order_unit (
    .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_is_store(alloc_is_store), .alloc_pc(alloc_pc), .alloc_idx(alloc_idx),
    .sa_valid(sa_valid), .sa_idx(sa_idx), .sa_addr(sa_addr),
    .sd_valid(sd_valid), .sd_idx(sd_idx),
    .la_valid(la_valid), .la_idx(la_idx), .la_addr(la_addr),
    .lx_valid(lx_valid), .lx_idx(lx_idx),
    .commit_valid(commit_valid),
    .squash_valid(squash_valid), .squash_idx(squash_idx),
    .issue_ok(issue_ok), .viol_valid(viol_valid), .viol_idx(viol_idx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit spec);
    rst_n = 1'b0;
    spec_mode = spec;
    repeat (2) tick();
    rst_n = 1'b1;
  endtask

  task automatic alloc(bit is_st, logic [31:0] pc);
    alloc_valid = 1'b1; alloc_is_store = is_st; alloc_pc = pc;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic st_addr(logic [3:0] i, logic [31:0] a);
    sa_valid = 1'b1; sa_idx = i; sa_addr = a;
    tick();
    sa_valid = 1'b0;
  endtask

  task automatic st_data(logic [3:0] i);
    sd_valid = 1'b1; sd_idx = i;
    tick();
    sd_valid = 1'b0;
  endtask

  task automatic ld_addr(logic [3:0] i, logic [31:0] a);
    la_valid = 1'b1; la_idx = i; la_addr = a;
    tick();
    la_valid = 1'b0;
  endtask

  task automatic ld_exec(logic [3:0] i);
    lx_valid = 1'b1; lx_idx = i;
    tick();
    lx_valid = 1'b0;
  endtask

  task automatic commit_one();
    commit_valid = 1'b1;
    tick();
    commit_valid = 1'b0;
  endtask

  task automatic squash_at(logic [3:0] i);
    squash_valid = 1'b1; squash_idx = i;
    tick();
    squash_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R1", "ready after reset", 32'(alloc_ready), 1);
    chk("R1", "first slot", 32'(alloc_idx), 0);
    chk("R3", "no permission", 32'(issue_ok), 0);
    chk("R7", "no violation", 32'(viol_valid), 0);
  endtask

  task automatic t_fill_and_wrap();
    do_reset(1'b0);
    for (int k = 0; k < 16; k++) begin
      chk("R1", "slot order", 32'(alloc_idx), 32'(k));
      alloc(1'b0, 32'h1000 + 32'(k * 4));
    end
    chk("R1", "ready when full", 32'(alloc_ready), 0);
    commit_one();
    chk("R10", "ready after commit", 32'(alloc_ready), 1);
    chk("R1", "wrapped slot", 32'(alloc_idx), 0);
  endtask

  task automatic t_basic_load();
    do_reset(1'b0);
    alloc(1'b0, 32'h200);
    chk("R3", "no address yet", 32'(issue_ok[0]), 0);
    ld_addr(4'd0, 32'h40);
    chk("R3", "address known", 32'(issue_ok[0]), 1);
    ld_exec(4'd0);
    chk("R3", "after execute", 32'(issue_ok[0]), 0);
  endtask

  task automatic t_conservative();
    do_reset(1'b0);
    alloc(1'b1, 32'h300);
    alloc(1'b0, 32'h304);
    ld_addr(4'd1, 32'h100);
    chk("R5", "unknown older store", 32'(issue_ok[1]), 0);
    st_addr(4'd0, 32'h200);
    chk("R5", "older store resolved apart", 32'(issue_ok[1]), 1);
    // partial match
    do_reset(1'b0);
    alloc(1'b1, 32'h300);
    alloc(1'b0, 32'h304);
    ld_addr(4'd1, 32'h0000_1234);
    st_addr(4'd0, 32'h0005_1234);
    chk("R4", "low-bit alias blocks", 32'(issue_ok[1]), 0);
    commit_one();
    chk("R10", "retired store unblocks", 32'(issue_ok[1]), 1);
    // younger store never blocks
    do_reset(1'b0);
    alloc(1'b0, 32'h310);
    alloc(1'b1, 32'h314);
    ld_addr(4'd0, 32'h80);
    chk("R5", "younger unknown store", 32'(issue_ok[0]), 1);
  endtask

  task automatic t_spec_train();
    do_reset(1'b1);
    alloc(1'b1, 32'h400);
    alloc(1'b0, 32'h404);
    ld_addr(4'd1, 32'h40);
    chk("R6", "issue past unknown store", 32'(issue_ok[1]), 1);
    ld_exec(4'd1);
    st_addr(4'd0, 32'h40);
    chk("R7", "violation raised", 32'(viol_valid), 1);
    chk("R7", "violating slot", 32'(viol_idx), 1);
    squash_at(4'd1);
    chk("R7", "single-cycle pulse", 32'(viol_valid), 0);
    chk("R11", "tail restored", 32'(alloc_idx), 1);
    chk("R11", "squashed load gone", 32'(issue_ok[1]), 0);
    alloc(1'b1, 32'h408);
    alloc(1'b0, 32'h404);
    alloc(1'b0, 32'h50c);
    ld_addr(4'd2, 32'h80);
    ld_addr(4'd3, 32'h90);
    chk("R8", "trained load waits", 32'(issue_ok[2]), 0);
    chk("R8", "other PC unaffected", 32'(issue_ok[3]), 1);
    st_data(4'd1);
    chk("R2", "data without address", 32'(issue_ok[2]), 0);
    st_data(4'd0);
    chk("R2", "older store still incomplete", 32'(issue_ok[2]), 0);
    st_addr(4'd1, 32'h300);
    chk("R8", "all older stores complete", 32'(issue_ok[2]), 1);
  endtask

  task automatic t_oldest_violation();
    do_reset(1'b1);
    alloc(1'b0, 32'h600);
    alloc(1'b1, 32'h604);
    ld_addr(4'd0, 32'h10);
    ld_exec(4'd0);
    st_addr(4'd1, 32'h10);
    chk("R7", "older load ignored", 32'(viol_valid), 0);
    do_reset(1'b1);
    alloc(1'b1, 32'h700);
    alloc(1'b0, 32'h704);
    alloc(1'b0, 32'h708);
    ld_addr(4'd1, 32'h20);
    ld_addr(4'd2, 32'h20);
    ld_exec(4'd2);
    ld_exec(4'd1);
    st_addr(4'd0, 32'h20);
    chk("R7", "violation among two", 32'(viol_valid), 1);
    chk("R7", "oldest named", 32'(viol_idx), 1);
  endtask

  task automatic t_periodic_clear();
    do_reset(1'b1);
    alloc(1'b1, 32'h800);
    alloc(1'b0, 32'h804);
    ld_addr(4'd1, 32'h30);
    ld_exec(4'd1);
    st_addr(4'd0, 32'h30);
    squash_at(4'd1);
    alloc(1'b0, 32'h804);
    ld_addr(4'd1, 32'h90);
    chk("R9", "trained before period", 32'(issue_ok[1]), 0);
    squash_at(4'd1);
    repeat (4100) tick();
    alloc(1'b0, 32'h804);
    ld_addr(4'd1, 32'h90);
    chk("R9", "bit wiped after period", 32'(issue_ok[1]), 1);
  endtask

  initial begin
    t_reset_state();
    t_fill_and_wrap();
    t_basic_load();
    t_conservative();
    t_spec_train();
    t_oldest_violation();
    t_periodic_clear();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule